// File: doc/BRIEF.md
# Five-Channel Compare/Capture Timer with Infrared Carrier Gating

This block is a 16-bit up-counter that drives five channels. Each channel either produces a pulse-width output, high while the count is below the channel's compare value, or records the count when a chosen edge arrives on its input pin. The count advances on a prescaled clock and returns to zero after it reaches a programmable period.

An 8-bit carrier timer sits beside the main counter. It has its own prescaler, its own period and one compare value, and it drives a carrier output. When infrared mode is selected, the main counter stops using its prescaler and moves forward once for each full carrier period. Every channel output is also gated by the carrier output. With this arrangement, bursts of a modulated remote-control signal come out without per-bit help from software.

All configuration goes through a single-cycle write/read register bus. The read data is combinational from the address. Reading the capture-flag register clears the flags.

Top module: `irPwmTimer`

## Requirements
- R1: After reset every channel output and the carrier output are low, and the count register (address 2) and the capture-flag register (address 6) read zero.
- R2: The main count steps by one on each advance and wraps to zero on the advance after it reaches the period (address 1) or any larger value. A write to address 2 loads the count, and that address reads back the live count.
- R3: The 2-bit prescale field in bits 1:0 of the main control register (address 0) selects division by 1, 8, 32 or 128 for the codes 0, 1, 2 and 3. Bit 2 of that register starts the count.
- R4: A channel in compare mode drives its output high exactly while the count is below its compare value (addresses 16 to 20 for channels 0 to 4). Over one period the output is high for min(compare, period+1) count steps.
- R5: A channel whose mode register (addresses 8 to 12) has bit 0 set captures the count on a rising edge of its input if bit 1 is set, and on a falling edge if bit 2 is set. The input passes through two synchronising flops first. The captured value reads at addresses 24 to 28, and an edge that is not selected captures nothing.
- R6: A capture sets the channel's bit in the flag register (address 6). The bit stays set until that register is read, and the read clears it.
- R7: The carrier count runs from 0 to its period (address 4) at the rate set by its own prescale field (carrier control at address 3, bits 1:0 with the same codes, bit 2 to run). The carrier output is high while the carrier count is below the carrier compare value (address 5).
- R8: With bit 3 of the main control register set, the main count advances once per completed carrier period, whatever the main prescale field holds.
- R9: In that mode each channel output is its compare output ANDed with the carrier output.
- R10: A channel in capture mode holds its output low.
- R11: Every writable register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears flags on a flag read) |
| addr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the current address |
| capIn | input | 5 | Asynchronous capture inputs, one per channel |
| chanOut | output | 5 | Channel outputs |
| carrierOut | output | 1 | Carrier timer output |

## Verification
The hardest case to reach from the ports is infrared mode. There, a channel's duty depends on two unrelated periods at once and on the main counter stepping in lock with carrier wraps. The bench sets both timers, lets them settle, and counts high cycles over a window of exactly (main period+1)×(carrier period+1) cycles. The count is then the product of the two duties whatever the starting phase. The capture cases freeze the counter and load a known count through the bus. Each edge can then be tied to one expected value, and an edge that is not selected shows up as a flag that stays clear.

// File: rtl/irtmrPkg.sv
package irtmrPkg;
  parameter int NUM_CH = 5;
  parameter int CNT_W  = 16;
  parameter int CAR_W  = 8;
  parameter int ADDR_W = 5;
  parameter int DATA_W = 16;
  parameter int PRE_W  = 7;
  parameter int MODE_W = 3;
  parameter int NUM_PRE = 2;

  localparam logic [ADDR_W-1:0] ADR_MAINCTL = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_MAINPER = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_MAINCNT = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_CARCTL  = 5'd3;
  localparam logic [ADDR_W-1:0] ADR_CARPER  = 5'd4;
  localparam logic [ADDR_W-1:0] ADR_CARCMP  = 5'd5;
  localparam logic [ADDR_W-1:0] ADR_FLAG    = 5'd6;
  localparam logic [ADDR_W-1:0] ADR_CARCNT  = 5'd7;
  localparam logic [ADDR_W-1:0] ADR_MODE    = 5'd8;
  localparam logic [ADDR_W-1:0] ADR_CMP     = 5'd16;
  localparam logic [ADDR_W-1:0] ADR_CAP     = 5'd24;

  typedef struct packed {
    logic mainCtlWr;
    logic mainPerWr;
    logic mainCntWr;
    logic carCtlWr;
    logic carPerWr;
    logic carCmpWr;
    logic flagRd;
    logic [NUM_CH-1:0] modeWr;
    logic [NUM_CH-1:0] cmpWr;
    logic mainTick;
    logic carTick;
    logic [DATA_W-1:0] data;
  } strobe_t;

  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] sel);
    case (sel)
      2'd0: preLimit = PRE_W'(0);
      2'd1: preLimit = PRE_W'(7);
      2'd2: preLimit = PRE_W'(31);
      default: preLimit = PRE_W'(127);
    endcase
  endfunction
endpackage

// File: rtl/irtmrCtrl.sv
module irtmrCtrl
  import irtmrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0] mainCtl,
  input  logic [2:0] carCtl,
  input  logic [CNT_W-1:0] mainPer,
  input  logic [CNT_W-1:0] mainCount,
  input  logic [CAR_W-1:0] carPer,
  input  logic [CAR_W-1:0] carCmp,
  input  logic [CAR_W-1:0] carCount,
  input  logic [NUM_CH-1:0][MODE_W-1:0] chMode,
  input  logic [NUM_CH-1:0][CNT_W-1:0] chCmp,
  input  logic [NUM_CH-1:0][CNT_W-1:0] chCap,
  input  logic [NUM_CH-1:0] capFlags,
  output strobe_t strb,
  output logic [DATA_W-1:0] rdData
);
  logic [1:0] preSel [NUM_PRE];
  logic       preRun [NUM_PRE];
  logic [NUM_PRE-1:0] preTick;

  assign preSel[0] = mainCtl[1:0];
  assign preRun[0] = mainCtl[2];
  assign preSel[1] = carCtl[1:0];
  assign preRun[1] = carCtl[2];

  for (genvar g = 0; g < NUM_PRE; g++) begin : gPre
    logic [PRE_W-1:0] preCnt;
    assign preTick[g] = preRun[g] && (preCnt == preLimit(preSel[g]));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) preCnt <= '0;
      else if (!preRun[g] || preTick[g]) preCnt <= '0;
      else preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.data      = wrData;
    strb.mainCtlWr = wrEn && (addr == ADR_MAINCTL);
    strb.mainPerWr = wrEn && (addr == ADR_MAINPER);
    strb.mainCntWr = wrEn && (addr == ADR_MAINCNT);
    strb.carCtlWr  = wrEn && (addr == ADR_CARCTL);
    strb.carPerWr  = wrEn && (addr == ADR_CARPER);
    strb.carCmpWr  = wrEn && (addr == ADR_CARCMP);
    strb.flagRd    = rdEn && (addr == ADR_FLAG);
    for (int i = 0; i < NUM_CH; i++) begin
      strb.modeWr[i] = wrEn && (addr == ADR_MODE + ADDR_W'(i));
      strb.cmpWr[i]  = wrEn && (addr == ADR_CMP + ADDR_W'(i));
    end
    strb.mainTick = preTick[0];
    strb.carTick  = preTick[1];
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_MAINCTL: rdData = DATA_W'(mainCtl);
      ADR_MAINPER: rdData = DATA_W'(mainPer);
      ADR_MAINCNT: rdData = DATA_W'(mainCount);
      ADR_CARCTL:  rdData = DATA_W'(carCtl);
      ADR_CARPER:  rdData = DATA_W'(carPer);
      ADR_CARCMP:  rdData = DATA_W'(carCmp);
      ADR_FLAG:    rdData = DATA_W'(capFlags);
      ADR_CARCNT:  rdData = DATA_W'(carCount);
      default:     rdData = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADR_MODE + ADDR_W'(i)) rdData = DATA_W'(chMode[i]);
      if (addr == ADR_CMP + ADDR_W'(i))  rdData = DATA_W'(chCmp[i]);
      if (addr == ADR_CAP + ADDR_W'(i))  rdData = DATA_W'(chCap[i]);
    end
  end
endmodule

// File: rtl/irtmrDatapath.sv
module irtmrDatapath
  import irtmrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [NUM_CH-1:0] capIn,
  output logic [NUM_CH-1:0] chanOut,
  output logic carrierOut,
  output logic [3:0] mainCtl,
  output logic [2:0] carCtl,
  output logic [CNT_W-1:0] mainPer,
  output logic [CNT_W-1:0] mainCount,
  output logic [CAR_W-1:0] carPer,
  output logic [CAR_W-1:0] carCmp,
  output logic [CAR_W-1:0] carCount,
  output logic [NUM_CH-1:0][MODE_W-1:0] chMode,
  output logic [NUM_CH-1:0][CNT_W-1:0] chCmp,
  output logic [NUM_CH-1:0][CNT_W-1:0] chCap,
  output logic [NUM_CH-1:0] capFlags
);
  logic carWrap;
  logic mainAdv;
  logic irMode;
  logic [NUM_CH-1:0] capHit;

  assign irMode     = mainCtl[3];
  assign carWrap    = strb.carTick && (carCount >= carPer);
  assign mainAdv    = mainCtl[2] && (irMode ? carWrap : strb.mainTick);
  assign carrierOut = carCount < carCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCtl   <= '0;
      carCtl    <= '0;
      mainPer   <= '0;
      mainCount <= '0;
      carPer    <= '0;
      carCmp    <= '0;
      carCount  <= '0;
      capFlags  <= '0;
    end else begin
      if (strb.mainCtlWr) mainCtl <= strb.data[3:0];
      if (strb.carCtlWr)  carCtl  <= strb.data[2:0];
      if (strb.mainPerWr) mainPer <= strb.data[CNT_W-1:0];
      if (strb.carPerWr)  carPer  <= strb.data[CAR_W-1:0];
      if (strb.carCmpWr)  carCmp  <= strb.data[CAR_W-1:0];
      if (strb.mainCntWr) mainCount <= strb.data[CNT_W-1:0];
      else if (mainAdv)   mainCount <= (mainCount >= mainPer) ? '0 : mainCount + 1'b1;
      if (strb.carTick)   carCount <= carWrap ? '0 : carCount + 1'b1;
      capFlags <= (strb.flagRd ? '0 : capFlags) | capHit;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic syncA, syncB, prevS;
    logic isCap;
    assign isCap     = chMode[i][0];
    assign capHit[i] = isCap && ((chMode[i][1] && syncB && !prevS) ||
                                 (chMode[i][2] && !syncB && prevS));
    assign chanOut[i] = !isCap && (mainCount < chCmp[i]) && (!irMode || carrierOut);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA     <= 1'b0;
        syncB     <= 1'b0;
        prevS     <= 1'b0;
        chMode[i] <= '0;
        chCmp[i]  <= '0;
        chCap[i]  <= '0;
      end else begin
        syncA <= capIn[i];
        syncB <= syncA;
        prevS <= syncB;
        if (strb.modeWr[i]) chMode[i] <= strb.data[MODE_W-1:0];
        if (strb.cmpWr[i])  chCmp[i]  <= strb.data[CNT_W-1:0];
        if (capHit[i])      chCap[i]  <= mainCount;
      end
    end
  end
endmodule

// File: rtl/irPwmTimer.sv
module irPwmTimer
  import irtmrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] capIn,
  output logic [NUM_CH-1:0] chanOut,
  output logic carrierOut
);
  strobe_t strb;
  logic [3:0] mainCtl;
  logic [2:0] carCtl;
  logic [CNT_W-1:0] mainPer, mainCount;
  logic [CAR_W-1:0] carPer, carCmp, carCount;
  logic [NUM_CH-1:0][MODE_W-1:0] chMode;
  logic [NUM_CH-1:0][CNT_W-1:0] chCmp, chCap;
  logic [NUM_CH-1:0] capFlags;

  irtmrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .mainCtl(mainCtl), .carCtl(carCtl), .mainPer(mainPer), .mainCount(mainCount),
    .carPer(carPer), .carCmp(carCmp), .carCount(carCount), .chMode(chMode),
    .chCmp(chCmp), .chCap(chCap), .capFlags(capFlags), .strb(strb), .rdData(rdData)
  );

  irtmrDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capIn(capIn), .chanOut(chanOut),
    .carrierOut(carrierOut), .mainCtl(mainCtl), .carCtl(carCtl), .mainPer(mainPer),
    .mainCount(mainCount), .carPer(carPer), .carCmp(carCmp), .carCount(carCount),
    .chMode(chMode), .chCmp(chCmp), .chCap(chCap), .capFlags(capFlags)
  );
endmodule

// File: rtl/irtmrChecker.sv
module irtmrChecker
  import irtmrPkg::*;
(
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] chanOut,
  input logic carrierOut,
  input logic [CNT_W-1:0] mainCount,
  input logic [CAR_W-1:0] carCount,
  input logic [3:0] mainCtl,
  input logic [NUM_CH-1:0][MODE_W-1:0] chMode,
  input logic [NUM_CH-1:0] capFlags
);
  logic [NUM_CH-1:0] capMask;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) capMask[i] = chMode[i][0];
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADR_MAINCNT) |=> (mainCount == $past(mainCount) ||
      mainCount == $past(mainCount) + 1'b1 || mainCount == '0)); // R2

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (carCount == $past(carCount) || carCount == $past(carCount) + 1'b1 ||
      carCount == '0)); // R7

  AST_IR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (mainCtl[3] && !carrierOut) |-> (chanOut == '0)); // R9

  AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (capMask != '0) |-> ((chanOut & capMask) == '0)); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && addr == ADR_FLAG) |=> ((capFlags & $past(capFlags)) == $past(capFlags))); // R6
endmodule

bind irPwmTimer irtmrChecker u_chk (.*);

// File: tb/sim_irPwmTimer.sv
`timescale 1ns/1ps
module sim_irPwmTimer;
  import irtmrPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_CH-1:0] capIn = '0;
  logic [NUM_CH-1:0] chanOut;
  logic carrierOut;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  irPwmTimer u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .chanOut(chanOut),
    .carrierOut(carrierOut));

  typedef struct packed {
    logic        ir;
    logic [1:0]  sel;
    logic [15:0] per;
    logic [15:0] cmp;
    logic [7:0]  cPer;
    logic [7:0]  cCmp;
    logic [15:0] win;
    logic [15:0] expHigh;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 16'd9, 16'd4,  8'd0, 8'd0, 16'd10,  16'd4},
    '{1'b0, 2'd0, 16'd9, 16'd0,  8'd0, 8'd0, 16'd10,  16'd0},
    '{1'b0, 2'd0, 16'd9, 16'd10, 8'd0, 8'd0, 16'd10,  16'd10},
    '{1'b0, 2'd0, 16'd9, 16'd9,  8'd0, 8'd0, 16'd10,  16'd9},
    '{1'b0, 2'd1, 16'd3, 16'd2,  8'd0, 8'd0, 16'd32,  16'd16},
    '{1'b0, 2'd2, 16'd1, 16'd1,  8'd0, 8'd0, 16'd64,  16'd32},
    '{1'b0, 2'd3, 16'd0, 16'd1,  8'd0, 8'd0, 16'd128, 16'd128},
    '{1'b1, 2'd3, 16'd3, 16'd2,  8'd4, 8'd2, 16'd20,  16'd4},
    '{1'b1, 2'd0, 16'd4, 16'd5,  8'd3, 8'd1, 16'd20,  16'd5}
  };

  task automatic check(input string req, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic measure(input int ch, input int win, output int hi);
    hi = 0;
    repeat (win) begin
      @(negedge clk);
      if (ch == NUM_CH) hi += int'(carrierOut);
      else hi += int'(chanOut[ch]);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int v;
    int hi;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1: reset state
    check("R1 chanOut", int'(chanOut), 0);
    check("R1 carrierOut", int'(carrierOut), 0);
    rd(ADR_MAINCNT, v); check("R1 count", v, 0);
    rd(ADR_FLAG, v);    check("R1 flags", v, 0);

    // Vector table: R3 R4 R8 R9
    for (int k = 0; k < NVEC; k++) begin
      int ch;
      string tag;
      ch = k % NUM_CH;
      tag = VECS[k].ir ? "R8 R9" : (VECS[k].sel != 0 ? "R3 R4" : "R4");
      wr(ADR_MAINCTL, 16'd0);
      wr(ADR_CARCTL, 16'd0);
      wr(ADR_MAINPER, VECS[k].per);
      for (int c = 0; c < NUM_CH; c++) begin
        wr(ADR_MODE + ADDR_W'(c), 16'd0);
        wr(ADR_CMP + ADDR_W'(c), (c == ch) ? VECS[k].cmp : 16'd0);
      end
      wr(ADR_CARPER, 16'(VECS[k].cPer));
      wr(ADR_CARCMP, 16'(VECS[k].cCmp));
      wr(ADR_MAINCNT, 16'd0);
      wr(ADR_CARCTL, 16'h0004);
      wr(ADR_MAINCTL, {12'd0, VECS[k].ir, 1'b1, VECS[k].sel});
      waitCyc(2 * int'(VECS[k].win));
      measure(ch, int'(VECS[k].win), hi);
      check(tag, hi, int'(VECS[k].expHigh));
    end

    // R7: carrier duty, divide by 1 then by 8
    wr(ADR_MAINCTL, 16'd0);
    wr(ADR_CARCTL, 16'd0);
    wr(ADR_CARPER, 16'd4);
    wr(ADR_CARCMP, 16'd2);
    wr(ADR_CARCTL, 16'h0004);
    waitCyc(10);
    measure(NUM_CH, 20, hi); check("R7 carrier div1", hi, 8);
    wr(ADR_CARCTL, 16'h0005);
    waitCyc(80);
    measure(NUM_CH, 40, hi); check("R7 carrier div8", hi, 16);

    // R2: count stays within period; load and read back
    wr(ADR_MAINPER, 16'd5);
    wr(ADR_MAINCTL, 16'h0004);
    for (int n = 0; n < 6; n++) begin
      rd(ADR_MAINCNT, v);
      check("R2 count<=period", int'(v <= 5), 1);
    end
    wr(ADR_MAINCTL, 16'd0);
    wr(ADR_MAINCNT, 16'h1234);
    rd(ADR_MAINCNT, v); check("R2 count load", v, 16'h1234);

    // R11: register readback
    wr(ADR_MAINPER, 16'h00A5);
    rd(ADR_MAINPER, v); check("R11 period", v, 16'h00A5);
    wr(ADR_CMP + ADDR_W'(2), 16'hBEEF);
    rd(ADR_CMP + ADDR_W'(2), v); check("R11 compare", v, 16'hBEEF);

    // R5 R6: rising capture on channel 1
    wr(ADR_MODE + ADDR_W'(1), 16'h0003);
    wr(ADR_MAINCNT, 16'h1234);
    @(negedge clk); capIn[1] = 1'b1;
    waitCyc(5);
    rd(ADR_CAP + ADDR_W'(1), v); check("R5 rising capture", v, 16'h1234);
    waitCyc(4);
    rd(ADR_FLAG, v); check("R6 flag set", v, 2);
    rd(ADR_FLAG, v); check("R6 flag cleared by read", v, 0);
    @(negedge clk); capIn[1] = 1'b0;
    waitCyc(5);
    rd(ADR_FLAG, v); check("R5 falling ignored in rising mode", v, 0);

    // R5: falling-only on channel 4
    wr(ADR_MODE + ADDR_W'(4), 16'h0005);
    wr(ADR_MAINCNT, 16'h0100);
    @(negedge clk); capIn[4] = 1'b1;
    waitCyc(5);
    rd(ADR_FLAG, v); check("R5 rising ignored in falling mode", v, 0);
    @(negedge clk); capIn[4] = 1'b0;
    waitCyc(5);
    rd(ADR_CAP + ADDR_W'(4), v); check("R5 falling capture", v, 16'h0100);
    rd(ADR_FLAG, v); check("R6 flag ch4", v, 16);

    // R5: both edges on channel 0
    wr(ADR_MODE + ADDR_W'(0), 16'h0007);
    wr(ADR_MAINCNT, 16'h0200);
    @(negedge clk); capIn[0] = 1'b1;
    waitCyc(5);
    rd(ADR_CAP + ADDR_W'(0), v); check("R5 both rise", v, 16'h0200);
    wr(ADR_MAINCNT, 16'h0300);
    @(negedge clk); capIn[0] = 1'b0;
    waitCyc(5);
    rd(ADR_CAP + ADDR_W'(0), v); check("R5 both fall", v, 16'h0300);

    // R10: capture-mode channel stays low, compare-mode goes high
    wr(ADR_MAINPER, 16'd9);
    wr(ADR_CMP + ADDR_W'(3), 16'hFFFF);
    wr(ADR_MODE + ADDR_W'(3), 16'h0001);
    wr(ADR_MAINCTL, 16'h0004);
    waitCyc(10);
    measure(3, 20, hi); check("R10 capture mode low", hi, 0);
    wr(ADR_MODE + ADDR_W'(3), 16'h0000);
    waitCyc(10);
    measure(3, 10, hi); check("R4 compare above period", hi, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule